// File: doc/BRIEF.md
# Debug Session Controller

This block runs a debug session between a halted soft processor core and a debugger on a host machine. The host link is byte-wide. Inbound bytes arrive over a valid/ready handshake. Replies leave through a one-byte holding slot that keeps its byte until the link takes it. A session can open in two ways. The first is a breakpoint that the core has already executed. The second is a suspend byte from the host, which makes the controller ask the pipeline to stall.

During a session the controller reads one command byte at a time. It passes register and memory work to external engines through a start pulse, and it waits for their done pulse. It answers each command with a single byte. A continue command ends the session: the controller asks the stall logic to let the pipeline run again, waits for that request to be acknowledged, and then returns to idle. While the core stays halted, the host may send suspend again, for example after a crash and reconnect. The controller acknowledges it and keeps the session open. An unknown byte gets a zero reply and the core stays halted.

Top module: `dbg_session_ctrl`

## Requirements
- R1: In idle, any received byte other than the suspend code 0x01 is consumed and has no effect: no reply byte, suspend stays low, and the controller remains in idle.
- R2: In idle, while `brk_hit` is high and the reply slot is empty, the controller sends the notification byte 0x80, leaves `suspend_req` low and enters the command-wait state.
- R3: In idle, the byte 0x01 sets `suspend_req` high, queues the acknowledge byte 0x01 and enters the command-wait state. The reply is valid in the cycle after the byte is accepted.
- R4: In command-wait, the byte 0x03 pulses `reg_start` high for exactly one cycle. No reply and no new byte is accepted until `reg_done`. After `reg_done`, the acknowledge byte 0x01 follows in the next cycle.
- R5: In command-wait, the byte 0x04 behaves like R4 but with `mem_start` and `mem_done`. The register engine is not started.
- R6: In command-wait, the byte 0x02 queues 0x01 and raises `release_req`. `release_req` stays high until `release_ack`. The cycle after `release_ack`, both `release_req` and `suspend_req` are low and the controller is in idle.
- R7: In command-wait, any byte other than 0x01 to 0x04 is answered with 0x00. `suspend_req` is not changed and the controller keeps waiting for commands.
- R8: In command-wait, the byte 0x01 is answered with 0x01, `suspend_req` stays high and the session continues.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged, so no reply is lost.
- R10: While `rst_n` is low, the controller returns to idle with `suspend_req`, `release_req`, `tx_valid`, `reg_start` and `mem_start` all low.
- R11: `rx_ready` is low while a reply waits in the slot, while an engine is busy and while a release is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Host byte present |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Controller accepts a host byte this cycle |
| tx_valid | output | 1 | Reply byte present |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Link takes the reply byte this cycle |
| brk_hit | input | 1 | Core is halted on an executed breakpoint (level) |
| suspend_req | output | 1 | Request to stall the pipeline |
| release_req | output | 1 | Request to release the pipeline |
| release_ack | input | 1 | Pipeline release done |
| reg_start | output | 1 | One-cycle start to the register engine |
| reg_done | input | 1 | Register engine finished |
| mem_start | output | 1 | One-cycle start to the memory engine |
| mem_done | input | 1 | Memory engine finished |

## Verification
The hardest cases to reach are the ones inside an open session. One is a second suspend from a host that has reconnected. Another is any of the 252 unknown bytes. Each of these must leave the core halted and still accept commands afterwards. To reach them, the bench first opens a session with a suspend byte and then sweeps every byte value in command-wait. After each reply it checks that `suspend_req` is still high. The bench also holds `tx_ready` low while a reply is pending, and keeps `release_ack` low for several cycles. This exposes the hold and stall paths, which a link that is always ready would hide.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_REG  = 3'd2,
    ST_MEM  = 3'd3,
    ST_REL  = 3'd4
  } sess_state_e;

  typedef enum logic [2:0] {
    OP_SUSP = 3'd0,
    OP_CONT = 3'd1,
    OP_REG  = 3'd2,
    OP_MEM  = 3'd3,
    OP_BAD  = 3'd4
  } host_op_e;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] C_SUSP = 8'h01,
  parameter logic [DW-1:0] C_CONT = 8'h02,
  parameter logic [DW-1:0] C_REG  = 8'h03,
  parameter logic [DW-1:0] C_MEM  = 8'h04
) (
  input  logic [DW-1:0] byte_i,
  output host_op_e      op_o
);
  always_comb begin
    if (byte_i == C_SUSP)      op_o = OP_SUSP;
    else if (byte_i == C_CONT) op_o = OP_CONT;
    else if (byte_i == C_REG)  op_o = OP_REG;
    else if (byte_i == C_MEM)  op_o = OP_MEM;
    else                       op_o = OP_BAD;
  end
endmodule

// File: rtl/dbg_tx_slot.sv
module dbg_tx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_data_i,
  output logic          empty_o,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready
);
  logic          full_q, full_d;
  logic [DW-1:0] data_q, data_d;
  logic          data_en;

  always_comb begin
    full_d  = full_q;
    data_en = 1'b0;
    data_d  = ld_data_i;
    if (ld_i) begin
      full_d  = 1'b1;
      data_en = 1'b1;
    end else if (full_q && tx_ready) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign empty_o  = !full_q;
  assign tx_valid = full_q;
  assign tx_data  = data_q;

  // R9: a loaded byte must never be overwritten before it leaves
  p_ld_only_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |-> !full_q);
  // R9: reply held while link stalls
  p_hold_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/dbg_session_fsm.sv
module dbg_session_fsm
  import dbg_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] R_ACK    = 8'h01,
  parameter logic [DW-1:0] R_ZERO   = 8'h00,
  parameter logic [DW-1:0] R_NOTIFY = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  host_op_e      op_i,
  output logic          rx_ready,
  input  logic          slot_empty_i,
  output logic          ld_o,
  output logic [DW-1:0] ld_data_o,
  input  logic          brk_hit,
  output logic          suspend_req,
  output logic          release_req,
  input  logic          release_ack,
  output logic          reg_start,
  input  logic          reg_done,
  output logic          mem_start,
  input  logic          mem_done
);
  sess_state_e st_q, st_d;
  logic susp_q, susp_d;
  logic rs_q, rs_d, ms_q, ms_d;
  logic rx_fire;

  assign rx_ready = slot_empty_i &&
                    ((st_q == ST_IDLE && !brk_hit) || st_q == ST_WAIT);
  assign rx_fire  = rx_valid && rx_ready;

  always_comb begin
    st_d      = st_q;
    susp_d    = susp_q;
    rs_d      = 1'b0;
    ms_d      = 1'b0;
    ld_o      = 1'b0;
    ld_data_o = R_ACK;
    unique case (st_q)
      ST_IDLE: begin
        if (brk_hit && slot_empty_i) begin
          ld_o      = 1'b1;
          ld_data_o = R_NOTIFY;
          st_d      = ST_WAIT;
        end else if (rx_fire && op_i == OP_SUSP) begin
          susp_d = 1'b1;
          ld_o   = 1'b1;
          st_d   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rx_fire) begin
          unique case (op_i)
            OP_SUSP: ld_o = 1'b1;
            OP_CONT: begin
              ld_o = 1'b1;
              st_d = ST_REL;
            end
            OP_REG: begin
              rs_d = 1'b1;
              st_d = ST_REG;
            end
            OP_MEM: begin
              ms_d = 1'b1;
              st_d = ST_MEM;
            end
            default: begin
              ld_o      = 1'b1;
              ld_data_o = R_ZERO;
            end
          endcase
        end
      end
      ST_REG: begin
        if (reg_done) begin
          ld_o = 1'b1;
          st_d = ST_WAIT;
        end
      end
      ST_MEM: begin
        if (mem_done) begin
          ld_o = 1'b1;
          st_d = ST_WAIT;
        end
      end
      ST_REL: begin
        if (release_ack) begin
          susp_d = 1'b0;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      susp_q <= 1'b0;
      rs_q   <= 1'b0;
      ms_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      susp_q <= susp_d;
      rs_q   <= rs_d;
      ms_q   <= ms_d;
    end
  end

  assign suspend_req = susp_q;
  assign release_req = (st_q == ST_REL);
  assign reg_start   = rs_q;
  assign mem_start   = ms_q;

  // R4 and R5: start pulses last one cycle and never overlap
  p_reg_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_start |=> !reg_start);
  p_mem_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |=> !mem_start);
  p_start_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_start && mem_start));
  // R6: release request held until acknowledged
  p_release_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (release_req && !release_ack) |=> release_req);
  p_release_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (release_req && release_ack) |=> (!release_req && !suspend_req));
  // R2: a break entry never raises suspend
  p_brk_no_susp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && brk_hit && slot_empty_i) |=> !suspend_req);
  // R11: no host byte accepted while an engine is busy
  p_busy_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_start || mem_start) |-> !rx_ready);
endmodule

// File: rtl/dbg_session_ctrl.sv
module dbg_session_ctrl
  import dbg_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] C_SUSP   = 8'h01,
  parameter logic [DW-1:0] C_CONT   = 8'h02,
  parameter logic [DW-1:0] C_REG    = 8'h03,
  parameter logic [DW-1:0] C_MEM    = 8'h04,
  parameter logic [DW-1:0] R_ACK    = 8'h01,
  parameter logic [DW-1:0] R_ZERO   = 8'h00,
  parameter logic [DW-1:0] R_NOTIFY = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          brk_hit,
  output logic          suspend_req,
  output logic          release_req,
  input  logic          release_ack,
  output logic          reg_start,
  input  logic          reg_done,
  output logic          mem_start,
  input  logic          mem_done
);
  host_op_e      op;
  logic          slot_empty;
  logic          ld;
  logic [DW-1:0] ld_data;

  dbg_cmd_decode #(
    .DW(DW), .C_SUSP(C_SUSP), .C_CONT(C_CONT), .C_REG(C_REG), .C_MEM(C_MEM)
  ) u_dec (
    .byte_i(rx_data),
    .op_o  (op)
  );

  dbg_session_fsm #(
    .DW(DW), .R_ACK(R_ACK), .R_ZERO(R_ZERO), .R_NOTIFY(R_NOTIFY)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .op_i        (op),
    .rx_ready    (rx_ready),
    .slot_empty_i(slot_empty),
    .ld_o        (ld),
    .ld_data_o   (ld_data),
    .brk_hit     (brk_hit),
    .suspend_req (suspend_req),
    .release_req (release_req),
    .release_ack (release_ack),
    .reg_start   (reg_start),
    .reg_done    (reg_done),
    .mem_start   (mem_start),
    .mem_done    (mem_done)
  );

  dbg_tx_slot #(.DW(DW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (ld),
    .ld_data_i(ld_data),
    .empty_o  (slot_empty),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready)
  );

  // R11: nothing accepted while a reply is still pending
  p_rx_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);
endmodule

// File: tb/dbg_session_ctrl_tb.sv
module dbg_session_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_ready, tx_valid, tx_ready;
  logic [7:0] rx_data, tx_data;
  logic       brk_hit, suspend_req, release_req, release_ack;
  logic       reg_start, reg_done, mem_start, mem_done;
  int         total = 0;
  int         bad = 0;

  always #2 clk = ~clk;

  dbg_session_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .brk_hit(brk_hit), .suspend_req(suspend_req),
    .release_req(release_req), .release_ack(release_ack),
    .reg_start(reg_start), .reg_done(reg_done),
    .mem_start(mem_start), .mem_done(mem_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    forever begin
      @(negedge clk);
      if (rx_ready) break;
    end
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_reply(input logic [7:0] exp, input string req);
    chk(tx_valid && tx_data == exp, req, {tx_valid, tx_data}, {1'b1, exp});
    @(negedge clk);
    chk(!tx_valid, req, tx_valid, 0);
  endtask

  task automatic run_engine(input bit is_mem, input string req);
    send_byte(is_mem ? 8'h04 : 8'h03);
    chk((is_mem ? mem_start : reg_start) && !(is_mem ? reg_start : mem_start),
        req, {reg_start, mem_start}, is_mem ? 1 : 2);
    chk(!rx_ready, "R11", rx_ready, 0);
    @(negedge clk);
    chk(!reg_start && !mem_start, req, {reg_start, mem_start}, 0);
    repeat (3) @(negedge clk);
    chk(!tx_valid && !rx_ready, req, {tx_valid, rx_ready}, 0);
    if (is_mem) mem_done = 1'b1; else reg_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    reg_done = 1'b0;
    expect_reply(8'h01, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!suspend_req && !release_req && !tx_valid && !reg_start && !mem_start,
        "R10", {suspend_req, release_req, tx_valid, reg_start, mem_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready, "R10", rx_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rx_valid = 0; rx_data = 0; tx_ready = 1; brk_hit = 0;
    release_ack = 0; reg_done = 0; mem_done = 0;
    do_reset();

    // R1: every non-suspend byte ignored in idle
    for (int b = 0; b < 256; b++) begin
      if (b == 1) continue;
      send_byte(b[7:0]);
      chk(!tx_valid && !suspend_req && rx_ready, "R1",
          {tx_valid, suspend_req, rx_ready}, 1);
    end

    // R3: host opens session
    send_byte(8'h01);
    chk(suspend_req, "R3", suspend_req, 1);
    expect_reply(8'h01, "R3");

    // R7: sweep unknown bytes in command-wait
    for (int b = 0; b < 256; b++) begin
      if (b >= 1 && b <= 4) continue;
      send_byte(b[7:0]);
      expect_reply(8'h00, "R7");
      chk(suspend_req, "R7", suspend_req, 1);
    end

    // R8: reconnect suspend
    send_byte(8'h01);
    expect_reply(8'h01, "R8");
    chk(suspend_req, "R8", suspend_req, 1);

    run_engine(1'b0, "R4");
    run_engine(1'b1, "R5");

    // R9: reply held while link stalls
    tx_ready = 1'b0;
    send_byte(8'h01);
    for (int i = 0; i < 4; i++) begin
      chk(tx_valid && tx_data == 8'h01, "R9", {tx_valid, tx_data}, 9'h101);
      chk(!rx_ready, "R11", rx_ready, 0);
      @(negedge clk);
    end
    tx_ready = 1'b1;
    expect_reply(8'h01, "R9");

    // R6: continue and delayed release
    send_byte(8'h02);
    chk(release_req, "R6", release_req, 1);
    expect_reply(8'h01, "R6");
    repeat (3) begin
      chk(release_req && suspend_req && !rx_ready, "R6",
          {release_req, suspend_req, rx_ready}, 6);
      @(negedge clk);
    end
    release_ack = 1'b1;
    @(negedge clk);
    release_ack = 1'b0;
    chk(!release_req && !suspend_req && rx_ready, "R6",
        {release_req, suspend_req, rx_ready}, 1);

    // R2: break-entered session
    brk_hit = 1'b1;
    @(negedge clk);
    chk(!suspend_req, "R2", suspend_req, 0);
    expect_reply(8'h80, "R2");
    run_engine(1'b0, "R4");
    send_byte(8'h02);
    expect_reply(8'h01, "R6");
    brk_hit = 1'b0;
    release_ack = 1'b1;
    @(negedge clk);
    release_ack = 1'b0;
    chk(!release_req && !suspend_req && rx_ready, "R2",
        {release_req, suspend_req, rx_ready}, 1);

    // R10: reset mid-session
    send_byte(8'h01);
    chk(suspend_req, "R3", suspend_req, 1);
    do_reset();
    send_byte(8'h03);
    chk(!reg_start && !tx_valid, "R1", {reg_start, tx_valid}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule